// File: doc/BRIEF.md
# SPI Serial Clock Divider with Timer Fallback

This block divides the system clock down to the serial clock of an SPI master. A 16-bit reload value, assembled from two byte-wide registers, sets how many system clock cycles pass between successive half-period edges of the serial clock. The block emits a one-cycle `sck_toggle` pulse at each such edge, and the shift logic flips its clock line on that pulse. The serial bit rate is therefore the system clock frequency divided by twice the reload value. A reload value of zero is treated as 65536, which gives the slowest rate.

When the SPI function is switched off, the same down-counter keeps running as a free 16-bit interval timer. If the timer interrupt enable is set, each expiry raises a one-cycle request toward the interrupt controller. That request is a separate output and never passes through any SPI status flag.

While the SPI is on but the block is not driving an active master transfer (slave mode, or master with no transfer), the counter is parked at the reload value. The first serial edge after a transfer starts therefore comes exactly one full interval later. Writing either reload byte forces a reload on the following clock, so a new rate starts at once.

Top module: `spi_sck_divider`

## Requirements
- R1: The reload value is `{brg_hi, brg_lo}` (high byte in bits 15:8), and the interval between expiries is that many system clock cycles.
- R2: With `spi_en`=1, `master_mode`=1 and `xfer_active`=1, `sck_toggle` is a one-cycle pulse repeating every reload-value cycles, and `tmr_irq` stays 0.
- R3: A reload value of 0 gives an interval of 65536 cycles.
- R4: With `spi_en`=0 and `tmr_irq_en`=1, `tmr_irq` is a one-cycle pulse repeating every reload-value cycles.
- R5: With `spi_en`=0, `sck_toggle` stays 0, and with `tmr_irq_en`=0 as well, `tmr_irq` stays 0.
- R6: `tmr_irq` and `sck_toggle` are never high together, and `tmr_irq` is never raised while `spi_en`=1.
- R7: A cycle with `brg_hi_wr` or `brg_lo_wr` high (sampled at edge E0) makes the counter load the new reload value at the next edge. The first pulse after that appears after edge E0+reload+1, and any older count is discarded.
- R8: While `spi_en`=1 and not (`master_mode`=1 and `xfer_active`=1), the counter holds the reload value and `sck_toggle` stays 0. When the transfer starts, the first pulse appears after the reload-value-th running edge.
- R9: During reset both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| brg_hi | input | 8 | Reload value high byte |
| brg_lo | input | 8 | Reload value low byte |
| brg_hi_wr | input | 1 | High byte written this cycle |
| brg_lo_wr | input | 1 | Low byte written this cycle |
| spi_en | input | 1 | SPI function enabled; 0 selects timer operation |
| tmr_irq_en | input | 1 | Timer interrupt enable |
| master_mode | input | 1 | SPI configured as master |
| xfer_active | input | 1 | Master transfer in progress |
| sck_toggle | output | 1 | One-cycle serial clock half-period pulse |
| tmr_irq | output | 1 | One-cycle timer request to the interrupt controller |

## Verification
The assertions check several rules on every cycle. The counter stays inside 1..65536. It steps down by one on each running cycle. It sits at the reload value while parked. A write always leads to a load. The two outputs stay mutually exclusive, and a timer request only follows a cycle in enabled timer mode. Only the bench scenarios can show the actual periods. These are the distance between pulses for random reload values in both modes, the latency after a write, the first edge after a parked transfer starts, and the full 65536-cycle interval for a zero reload.

// File: rtl/brg_pkg.sv
package brg_pkg;
    typedef enum logic [1:0] {
        BRG_PARK  = 2'd0,
        BRG_SPI   = 2'd1,
        BRG_TIMER = 2'd2
    } brg_mode_e;
endpackage

// File: rtl/brg_reload_sel.sv
module brg_reload_sel #(
    parameter int BYTE_W = 8,
    localparam int REL_W = 2 * BYTE_W,
    localparam int CNT_W = REL_W + 1
) (
    input  logic [BYTE_W-1:0] hi_byte,
    input  logic [BYTE_W-1:0] lo_byte,
    output logic [CNT_W-1:0]  eff_count
);
    logic [REL_W-1:0] raw;

    always_comb begin
        raw = {hi_byte, lo_byte};
        if (raw == '0) begin
            eff_count = CNT_W'(1) << REL_W;
        end else begin
            eff_count = {1'b0, raw};
        end
    end
endmodule

// File: rtl/brg_mode_dec.sv
module brg_mode_dec
    import brg_pkg::*;
(
    input  logic      spi_en,
    input  logic      master_mode,
    input  logic      xfer_active,
    output brg_mode_e mode
);
    always_comb begin
        if (!spi_en) begin
            mode = BRG_TIMER;
        end else if (master_mode && xfer_active) begin
            mode = BRG_SPI;
        end else begin
            mode = BRG_PARK;
        end
    end
endmodule

// File: rtl/brg_down_cnt.sv
module brg_down_cnt
    import brg_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  brg_mode_e        mode,
    input  logic [CNT_W-1:0] eff_count,
    input  logic             reload_wr,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pend;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (mode == BRG_PARK) begin
            st_d.cnt  = eff_count;
            st_d.pend = 1'b0;
        end else if (st_q.pend) begin
            st_d.cnt  = eff_count;
            st_d.pend = 1'b0;
        end else if (st_q.cnt == CNT_W'(1)) begin
            expire   = 1'b1;
            st_d.cnt = eff_count;
        end else begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
        if (reload_wr && mode != BRG_PARK) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= CNT_W'(1);
            st_q.pend <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0) && (st_q.cnt <= (CNT_W'(1) << (CNT_W - 1))));

    assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != BRG_PARK && !st_q.pend && st_q.cnt > CNT_W'(1))
        |=> st_q.cnt == $past(st_q.cnt) - CNT_W'(1));

    assert_write_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_wr && mode != BRG_PARK) |=> st_q.pend);

    assert_pend_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && mode != BRG_PARK) |=> st_q.cnt == $past(eff_count));

    assert_park_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == BRG_PARK) |=> st_q.cnt == $past(eff_count));
endmodule

// File: rtl/brg_evt_out.sv
module brg_evt_out
    import brg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      expire,
    input  brg_mode_e mode,
    input  logic      irq_en,
    output logic      sck_toggle,
    output logic      tmr_irq
);
    typedef struct packed {
        logic sck;
        logic irq;
    } evt_state_t;

    evt_state_t ev_d, ev_q;

    always_comb begin
        ev_d.sck = expire && (mode == BRG_SPI);
        ev_d.irq = expire && (mode == BRG_TIMER) && irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q <= '0;
        end else begin
            ev_q <= ev_d;
        end
    end

    assign sck_toggle = ev_q.sck;
    assign tmr_irq    = ev_q.irq;

    assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sck_toggle, tmr_irq}));

    assert_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_irq |-> $past(irq_en && mode == BRG_TIMER));

    assert_sck_only_spi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sck_toggle |-> $past(mode == BRG_SPI));

    always_comb begin
        if (!rst_n) begin
            assert_reset_quiet_R9: assert (!sck_toggle && !tmr_irq);
        end
    end
endmodule

// File: rtl/spi_sck_divider.sv
module spi_sck_divider
    import brg_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int REL_W = 2 * BYTE_W,
    localparam int CNT_W = REL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] brg_hi,
    input  logic [BYTE_W-1:0] brg_lo,
    input  logic              brg_hi_wr,
    input  logic              brg_lo_wr,
    input  logic              spi_en,
    input  logic              tmr_irq_en,
    input  logic              master_mode,
    input  logic              xfer_active,
    output logic              sck_toggle,
    output logic              tmr_irq
);
    logic [CNT_W-1:0] eff_count;
    brg_mode_e        mode;
    logic             expire;
    logic             reload_wr;

    assign reload_wr = brg_hi_wr | brg_lo_wr;

    brg_reload_sel #(.BYTE_W(BYTE_W)) u_sel (
        .hi_byte   (brg_hi),
        .lo_byte   (brg_lo),
        .eff_count (eff_count)
    );

    brg_mode_dec u_mode (
        .spi_en      (spi_en),
        .master_mode (master_mode),
        .xfer_active (xfer_active),
        .mode        (mode)
    );

    brg_down_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .eff_count (eff_count),
        .reload_wr (reload_wr),
        .expire    (expire)
    );

    brg_evt_out u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire     (expire),
        .mode       (mode),
        .irq_en     (tmr_irq_en),
        .sck_toggle (sck_toggle),
        .tmr_irq    (tmr_irq)
    );
endmodule

// File: tb/spi_sck_divider_tb.sv
module spi_sck_divider_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] brg_hi = 8'd0;
    logic [7:0] brg_lo = 8'd0;
    logic       brg_hi_wr = 1'b0;
    logic       brg_lo_wr = 1'b0;
    logic       spi_en = 1'b0;
    logic       tmr_irq_en = 1'b0;
    logic       master_mode = 1'b0;
    logic       xfer_active = 1'b0;
    logic       sck_toggle;
    logic       tmr_irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    spi_sck_divider u_dut (
        .clk(clk), .rst_n(rst_n), .brg_hi(brg_hi), .brg_lo(brg_lo),
        .brg_hi_wr(brg_hi_wr), .brg_lo_wr(brg_lo_wr), .spi_en(spi_en),
        .tmr_irq_en(tmr_irq_en), .master_mode(master_mode),
        .xfer_active(xfer_active), .sck_toggle(sck_toggle), .tmr_irq(tmr_irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int eff_of(input int v);
        return (v == 0) ? 65536 : v;
    endfunction

    function automatic logic pick(input bit sel);
        return sel ? tmr_irq : sck_toggle;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse(input bit sel, input int limit, output int n, output int other);
        n = 0;
        other = 0;
        while (n < limit) begin
            @(negedge clk);
            n++;
            if (pick(!sel)) other++;
            if (pick(sel)) break;
        end
    endtask

    task automatic quiet(input int len, output int hits_s, output int hits_i);
        hits_s = 0;
        hits_i = 0;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            if (sck_toggle) hits_s++;
            if (tmr_irq) hits_i++;
        end
    endtask

    task automatic write_and_time(input int v, input bit lo_only, input bit sel,
                                  input int limit, output int n);
        @(negedge clk);
        brg_hi = v[15:8];
        brg_lo = v[7:0];
        brg_lo_wr = 1'b1;
        brg_hi_wr = !lo_only;
        n = 0;
        while (n < limit) begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                brg_lo_wr = 1'b0;
                brg_hi_wr = 1'b0;
            end else if (pick(sel)) begin
                break;
            end
        end
    endtask

    task automatic set_mode(input bit spi, input bit irq_en, input bit mst, input bit act);
        @(negedge clk);
        spi_en = spi;
        tmr_irq_en = irq_en;
        master_mode = mst;
        xfer_active = act;
    endtask

    initial begin
        int n, oth, hs, hi;
        void'($urandom(32'h1d5eed));
        brg_hi = 8'h00;
        brg_lo = 8'h05;
        repeat (3) @(negedge clk);
        chk(!sck_toggle && !tmr_irq, "R9 reset quiet", {sck_toggle, tmr_irq}, 0);
        rst_n = 1'b1;

        // R2, R7: SPI master running, reload 3
        set_mode(1, 0, 1, 1);
        write_and_time(3, 0, 0, 100, n);
        chk(n == eff_of(3) + 2, "R7 latency after write", n, eff_of(3) + 2);
        wait_pulse(0, 100, n, oth);
        chk(n == 3, "R2 sck period", n, 3);
        wait_pulse(0, 100, n, oth);
        chk(n == 3 && oth == 0, "R2 sck period, no irq", n * 10 + oth, 30);

        // R8: parked while no transfer
        set_mode(1, 1, 1, 0);
        write_and_time(7, 0, 0, 3, n);
        quiet(30, hs, hi);
        chk(hs == 0 && hi == 0, "R8 parked no pulses", hs + hi, 0);
        @(negedge clk);
        xfer_active = 1'b1;
        wait_pulse(0, 100, n, oth);
        chk(n == 7, "R8 first edge after start", n, 7);

        // R8: slave mode holds
        set_mode(1, 1, 0, 1);
        quiet(40, hs, hi);
        chk(hs == 0 && hi == 0, "R8 slave no pulses", hs + hi, 0);

        // R1, R4: timer with multi-byte reload, low-byte-only write
        set_mode(0, 1, 0, 0);
        write_and_time(16'h0102, 0, 1, 1000, n);
        chk(n == 258 + 2, "R1 two-byte reload latency", n, 260);
        wait_pulse(1, 1000, n, oth);
        chk(n == 258 && oth == 0, "R4 timer period, R5 no sck", n, 258);
        write_and_time(16'h0109, 1, 1, 1000, n);
        chk(n == 265 + 2, "R7 low byte write reloads", n, 267);

        // R5: timer with interrupt disabled
        set_mode(0, 0, 1, 1);
        write_and_time(9, 0, 1, 3, n);
        quiet(40, hs, hi);
        chk(hs == 0 && hi == 0, "R5 timer irq disabled", hs + hi, 0);

        // R6: SPI enabled never raises irq
        set_mode(1, 1, 1, 1);
        quiet(40, hs, hi);
        chk(hi == 0 && hs > 0, "R6 no irq in SPI mode", hi, 0);

        // random reloads and modes
        for (int i = 0; i < 12; i++) begin
            int v;
            bit tm;
            v = $urandom_range(1, 40);
            tm = $urandom_range(0, 1);
            set_mode(!tm, 1, 1, 1);
            write_and_time(v, 0, tm, 200, n);
            chk(n == eff_of(v) + 2, tm ? "R7 random timer latency" : "R7 random sck latency",
                n, eff_of(v) + 2);
            wait_pulse(tm, 200, n, oth);
            chk(n == eff_of(v) && oth == 0, tm ? "R4 random timer period" : "R2 random sck period",
                n, eff_of(v));
        end

        // R3: zero reload means 65536
        set_mode(0, 1, 0, 0);
        write_and_time(0, 0, 1, 70000, n);
        chk(n == 65536 + 2, "R3 zero reload interval", n, 65538);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule